// File: doc/BRIEF.md
# Cartridge ROM Bank Switching Controller

This block sits between a host bus with 16-bit addresses and 8-bit data and a 256 KB parallel ROM. The host always sees ROM bank 0 in its lowest 16 KB. The next 16 KB of host space is a window whose ROM bank the host picks at run time by writing a bank number into a small register. The block drives ROM address bits 17..14 and the ROM's active-low chip and output enables. The host's own address lines 13..0 go straight to the ROM.

The bank register is written through a fully decoded address range. Only the host's three top address bits, its write strobe and its chip-select line take part in the decode, so stores to work RAM or to its mirror area can never disturb the bank. The host bus is slow and asynchronous to the block clock. The write strobe is therefore resynchronised. Address and data are held in capture registers while the strobe is low, and the new bank takes effect once the synchronised rising edge of the strobe is seen.

Top module: `rom_bank_ctrl`

## Requirements
- R1: When host address bits {A15,A14} are 2'b00, ROM address bits 17..14 are 0 and the ROM chip enable is asserted (low).
- R2: When {A15,A14} are 2'b01, ROM address bits 17..14 equal the current bank register value and the chip enable is asserted.
- R3: When A15 is 1, the ROM chip enable is deasserted (high) and ROM address bits 17..14 are 0.
- R4: A host write with {A15,A14,A13} = 3'b001 and chip-select high loads data bits 3..0 into the bank register. The new bank is visible no later than the third clock edge after the write strobe rises.
- R5: A write whose {A15,A14,A13} is any value other than 3'b001 leaves the bank register unchanged. This includes 3'b110 and 3'b111.
- R6: A write made while the chip-select input is low leaves the bank register unchanged.
- R7: Writing the value 0 to data bits 3..0 selects bank 1.
- R8: After reset the bank register holds 1.
- R9: Data bits 7..4 have no effect on the loaded bank.
- R10: The ROM output enable is asserted (low) only while A15 is 0 and the write strobe is high.
- R11: The bank register changes only on a detected rising edge of the synchronised write strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr_top | input | 3 | Host address bits {A15,A14,A13} |
| host_data | input | 8 | Host data bus |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_cs_n | input | 1 | Host chip-select, active low, high on register writes |
| rom_bank_addr | output | 4 | ROM address bits 17..14 |
| rom_ce_n | output | 1 | ROM chip enable, active low |
| rom_oe_n | output | 1 | ROM output enable, active low |

## Verification
The hardest case to reach from the ports is a store to work RAM (top bits 3'b110 or 3'b111, chip-select low) that carries a valid-looking bank number. The bank must stay untouched, and the only way to see that is to read back through the switchable window afterwards. The stimulus mixes such writes, cross-qualified ones (right range with chip-select low, wrong range with chip-select high) and accepted writes in a seeded random sequence. The data values include zero and have random upper nibbles. After every write the bench reads the window and compares against a bench model of the bank.

// File: rtl/rbc_pkg.sv
package rbc_pkg;

   typedef enum logic [1:0] {
      WIN_FIXED    = 2'd0,
      WIN_SWITCH   = 2'd1,
      WIN_UNMAPPED = 2'd2
   } win_e;

   function automatic win_e decode_win(input logic [2:0] top);
      if (top[2])
         return WIN_UNMAPPED;
      else if (top[1])
         return WIN_SWITCH;
      else
         return WIN_FIXED;
   endfunction

endpackage

// File: rtl/rbc_strobe_sync.sv
module rbc_strobe_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe_n,
   output logic strobe_low,
   output logic strobe_rise
);
   logic [STAGES-1:0] chain_q;
   logic              last_q;

   generate
      if (STAGES < 2) begin : g_bad
         $error("rbc_strobe_sync: STAGES must be at least 2");
      end
   endgenerate

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain_q[0] <= 1'b1;
               else        chain_q[0] <= strobe_n;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain_q[gi] <= 1'b1;
               else        chain_q[gi] <= chain_q[gi-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) last_q <= 1'b1;
      else        last_q <= chain_q[STAGES-1];

   assign strobe_low  = ~chain_q[STAGES-1];
   assign strobe_rise = chain_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/rbc_bank_reg.sv
module rbc_bank_reg #(
   parameter int           BANK_W     = 4,
   parameter int           DATA_W     = 8,
   parameter logic [2:0]   SEL_CODE   = 3'b001,
   parameter bit           ZERO_REMAP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        addr_top,
   input  logic              cs_n,
   input  logic [DATA_W-1:0] data,
   input  logic              strobe_low,
   input  logic              strobe_rise,
   output logic [BANK_W-1:0] bank_q
);
   localparam logic [BANK_W-1:0] BANK_ONE = BANK_W'(1);

   logic              hit_q;
   logic [BANK_W-1:0] nib_q;
   logic [BANK_W-1:0] nib_fixed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_q <= 1'b0;
         nib_q <= '0;
      end else if (strobe_low) begin
         hit_q <= (addr_top == SEL_CODE) && cs_n;
         nib_q <= data[BANK_W-1:0];
      end
   end

   generate
      if (ZERO_REMAP) begin : g_remap
         assign nib_fixed = (nib_q == '0) ? BANK_ONE : nib_q;
      end else begin : g_raw
         assign nib_fixed = nib_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         bank_q <= BANK_ONE;
      else if (strobe_rise && hit_q)
         bank_q <= nib_fixed;
   end

endmodule

// File: rtl/rbc_addr_map.sv
module rbc_addr_map
   import rbc_pkg::*;
#(
   parameter int BANK_W = 4
) (
   input  logic [2:0]        addr_top,
   input  logic              wr_n,
   input  logic [BANK_W-1:0] bank,
   output logic [BANK_W-1:0] rom_hi,
   output logic              ce_n,
   output logic              oe_n
);
   win_e win;

   always_comb begin
      win  = decode_win(addr_top);
      ce_n = 1'b1;
      rom_hi = '0;
      unique case (win)
         WIN_FIXED:  ce_n = 1'b0;
         WIN_SWITCH: begin
            ce_n   = 1'b0;
            rom_hi = bank;
         end
         default:    ce_n = 1'b1;
      endcase
      oe_n = ce_n | ~wr_n;
   end

endmodule

// File: rtl/rom_bank_ctrl.sv
module rom_bank_ctrl #(
   parameter int         BANK_W      = 4,
   parameter int         DATA_W      = 8,
   parameter int         SYNC_STAGES = 2,
   parameter logic [2:0] SEL_CODE    = 3'b001,
   parameter bit         ZERO_REMAP  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        host_addr_top,
   input  logic [DATA_W-1:0] host_data,
   input  logic              host_wr_n,
   input  logic              host_cs_n,
   output logic [BANK_W-1:0] rom_bank_addr,
   output logic              rom_ce_n,
   output logic              rom_oe_n
);
   generate
      if (BANK_W < 1 || BANK_W > 8) begin : g_bad_bank
         $error("rom_bank_ctrl: BANK_W out of range");
      end
      if (DATA_W < BANK_W) begin : g_bad_data
         $error("rom_bank_ctrl: DATA_W narrower than BANK_W");
      end
   endgenerate

   logic              strobe_low;
   logic              strobe_rise;
   logic [BANK_W-1:0] bank_q;

   rbc_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk         (clk),
      .rst_n       (rst_n),
      .strobe_n    (host_wr_n),
      .strobe_low  (strobe_low),
      .strobe_rise (strobe_rise)
   );

   rbc_bank_reg #(
      .BANK_W     (BANK_W),
      .DATA_W     (DATA_W),
      .SEL_CODE   (SEL_CODE),
      .ZERO_REMAP (ZERO_REMAP)
   ) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .addr_top    (host_addr_top),
      .cs_n        (host_cs_n),
      .data        (host_data),
      .strobe_low  (strobe_low),
      .strobe_rise (strobe_rise),
      .bank_q      (bank_q)
   );

   rbc_addr_map #(.BANK_W(BANK_W)) u_map (
      .addr_top (host_addr_top),
      .wr_n     (host_wr_n),
      .bank     (bank_q),
      .rom_hi   (rom_bank_addr),
      .ce_n     (rom_ce_n),
      .oe_n     (rom_oe_n)
   );

endmodule

// File: rtl/rbc_checker.sv
module rbc_checker #(
   parameter int BANK_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [2:0]        host_addr_top,
   input logic              host_wr_n,
   input logic [BANK_W-1:0] rom_bank_addr,
   input logic              rom_ce_n,
   input logic              rom_oe_n,
   input logic [BANK_W-1:0] bank_q,
   input logic              strobe_rise
);
   a_r1_fixed_window: assert property (@(posedge clk) disable iff (!rst_n)
      (host_addr_top[2:1] == 2'b00) |-> (rom_bank_addr == '0 && !rom_ce_n));

   a_r2_switch_window: assert property (@(posedge clk) disable iff (!rst_n)
      (host_addr_top[2:1] == 2'b01) |-> (rom_bank_addr == bank_q && !rom_ce_n));

   a_r3_upper_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
      host_addr_top[2] |-> (rom_ce_n && rom_bank_addr == '0));

   a_r7_window_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      (host_addr_top[2:1] == 2'b01) |-> (rom_bank_addr != '0));

   a_r10_oe_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      !rom_oe_n |-> (!host_addr_top[2] && host_wr_n));

   a_r11_bank_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe_rise |=> $stable(bank_q));

endmodule

bind rom_bank_ctrl rbc_checker #(.BANK_W(BANK_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .host_addr_top (host_addr_top),
   .host_wr_n     (host_wr_n),
   .rom_bank_addr (rom_bank_addr),
   .rom_ce_n      (rom_ce_n),
   .rom_oe_n      (rom_oe_n),
   .bank_q        (bank_q),
   .strobe_rise   (strobe_rise)
);

// File: tb/rom_bank_ctrl_tb_top.sv
module rom_bank_ctrl_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] addr_top = 3'b000;
   logic [7:0] data = 8'h00;
   logic       wr_n = 1'b1;
   logic       cs_n = 1'b1;
   logic [3:0] rom_bank_addr;
   logic       rom_ce_n;
   logic       rom_oe_n;

   int checks = 0;
   int errors = 0;
   logic [3:0] exp_bank = 4'd1;
   bit done = 1'b0;

   always #4 clk = ~clk;

   rom_bank_ctrl dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .host_addr_top (addr_top),
      .host_data     (data),
      .host_wr_n     (wr_n),
      .host_cs_n     (cs_n),
      .rom_bank_addr (rom_bank_addr),
      .rom_ce_n      (rom_ce_n),
      .rom_oe_n      (rom_oe_n)
   );

   function automatic logic [3:0] exp_hi(input logic [2:0] top, input logic [3:0] bank);
      if (top[2]) return 4'd0;
      if (top[1]) return bank;
      return 4'd0;
   endfunction

   function automatic logic [3:0] next_bank(input logic [3:0] cur, input logic [2:0] top,
                                            input logic cs, input logic [7:0] d);
      if (top != 3'b001 || !cs) return cur;
      if (d[3:0] == 4'd0) return 4'd1;
      return d[3:0];
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic host_write(input logic [2:0] top, input logic cs, input logic [7:0] d);
      @(negedge clk);
      addr_top = top; cs_n = cs; data = d;
      @(negedge clk);
      wr_n = 1'b0;
      repeat (4) @(negedge clk);
      wr_n = 1'b1;
      repeat (4) @(negedge clk);
      exp_bank = next_bank(exp_bank, top, cs, d);
   endtask

   task automatic read_window(input string req);
      @(negedge clk);
      addr_top = 3'b010; cs_n = 1'b0; wr_n = 1'b1;
      #1;
      check(req, {4'd0, rom_bank_addr}, {4'd0, exp_bank});
   endtask

   task automatic check_map(input logic [2:0] top, input logic w);
      @(negedge clk);
      addr_top = top; wr_n = w;
      #1;
      check(top[2] ? "R3" : (top[1] ? "R2" : "R1"), {4'd0, rom_bank_addr}, {4'd0, exp_hi(top, exp_bank)});
      check(top[2] ? "R3" : "R1", {7'd0, rom_ce_n}, {7'd0, top[2]});
      check("R10", {7'd0, rom_oe_n}, {7'd0, top[2] | ~w});
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R8: reset value
      read_window("R8");

      // R4: basic accepted write, check timing on third edge after rise
      @(negedge clk);
      addr_top = 3'b001; cs_n = 1'b1; data = 8'h05;
      @(negedge clk); wr_n = 1'b0;
      repeat (4) @(negedge clk);
      wr_n = 1'b1;
      repeat (2) @(negedge clk);
      addr_top = 3'b010; #1;
      check("R11", {4'd0, rom_bank_addr}, 8'h01);
      @(negedge clk); #1;
      check("R4", {4'd0, rom_bank_addr}, 8'h05);
      exp_bank = 4'd5;

      // R7: zero maps to bank 1
      host_write(3'b001, 1'b1, 8'h00); read_window("R7");
      // R9: upper nibble ignored
      host_write(3'b001, 1'b1, 8'hAC); read_window("R9");
      // R5: work RAM and mirror writes ignored
      host_write(3'b110, 1'b1, 8'h03); read_window("R5");
      host_write(3'b111, 1'b0, 8'h07); read_window("R5");
      host_write(3'b000, 1'b1, 8'h02); read_window("R5");
      // R6: chip-select low blocks the write
      host_write(3'b001, 1'b0, 8'h09); read_window("R6");
      host_write(3'b001, 1'b1, 8'h0F); read_window("R4");

      for (int t = 0; t < 8; t++) begin
         check_map(3'(t), 1'b1);
         check_map(3'(t), 1'b0);
      end

      for (int i = 0; i < 150; i++) begin
         logic [2:0] top;
         logic       cs;
         logic [7:0] d;
         top = ($urandom % 2) ? 3'b001 : 3'($urandom);
         cs  = 1'($urandom);
         d   = ($urandom % 8 == 0) ? {4'($urandom), 4'h0} : 8'($urandom);
         host_write(top, cs, d);
         read_window("R4");
         if (i % 10 == 0) check_map(3'($urandom), 1'($urandom));
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule